// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps calendar time in packed BCD and shows it to a host as eight byte registers. These registers sit at the top eight addresses of a byte-wide address space. One live set of counters advances on a one-second tick input. The host never reads these counters directly. It reads a shadow copy, which the block refreshes from the counters in one step after each tick. The time fields are seconds, minutes, hours, day of week, date, month, two-digit year and a century flag.

Two control bits let the host work with the shadow safely. The freeze bit stops the refresh so that a multi-byte read is coherent, and the counters keep running meanwhile. The load bit also stops the refresh, so the host can write a complete new time. When the host clears the load bit, the shadow is copied into the counters. A stop bit in the seconds register halts counting. A century-enable bit decides whether the century flag toggles when the year rolls over.

The host port is a plain register port, not a stream. A write takes one cycle. A read that hits the window returns data one cycle later, with a one-cycle valid pulse. There is no back-pressure in either direction.

Top module: `rtc_regfile`

## Requirements
- R1: Only addresses whose upper bits are all ones hit the window, so offsets 0 to 7 are the top eight addresses. A read that hits returns its byte on `rdata`, with `rd_valid` high, on the cycle after `rd_en`. A read outside the window never raises `rd_valid`.
- R2: After reset the registers read as follows: offset 0 reads 00h, offset 1 reads 80h, offsets 2 and 3 read 00h, offsets 4, 5 and 6 read 01h, and offset 7 reads 00h.
- R3: The offset layout is: 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. All values are BCD. Seconds and minutes wrap from 59 to 00 and carry onward. Hours wrap from 23 to 00 and advance both the date and the day of week. Day of week sits in offset 4 bits 2:0 and wraps from 7 to 1.
- R4: Date wraps to 01 after the last day of the month, and the month then advances, wrapping from 12 to 01. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is a multiple of four and 28 otherwise. All other months have 31 days.
- R5: When the year wraps from 99 to 00, the century flag (offset 4 bit 4) toggles if century-enable (offset 4 bit 5) is 1. If century-enable is 0, the flag keeps its value.
- R6: While the freeze bit (offset 0 bit 6) is 1, the visible registers keep their values across ticks and the counters keep running. After the bit is cleared, the next tick shows the advanced count.
- R7: While the load bit (offset 0 bit 7) is 1, ticks do not refresh the visible registers. A control write that clears this bit copies offsets 1 to 7 into the counters, and the next tick counts on from the loaded time.
- R8: The stop bit (offset 1 bit 7) resets to 1 and takes effect when it is written. While it is 1, ticks do not advance the counters.
- R9: The century flag accepts host writes only while the load bit is set. Century-enable accepts writes at any time.
- R10: Bits that have no defined function read as 0, and host writes to them are ignored. These are offset 0 bits 5:0, offset 2 bit 7, offset 3 bits 7:6, offset 4 bits 7:6 and 3, offset 5 bits 7:6, and offset 6 bits 7:5.
- R11: When neither control bit is set, a host write to a time register lands in the visible copy. The refresh after the next tick then replaces it with the counter value.
- R12: The visible registers all change together on the second clock edge after a sampled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle pulse after a read that hits the window |

## Verification
The time chain is loaded through the load bit with values that sit one second before a boundary, and then ticked once. The boundaries are: a minute-hour-day crossing into March in a non-leap year, into February 29 in a leap year whose tens digit is odd, out of a 30-day month, and across a year wrap both with and without century-enable. These cases separate the carry logic from the month-length table and from the leap test. Freeze, load and stop are each driven across two ticks, which shows the difference between a visible value that is held and counters that are held. Direct writes to time registers with no control bit set, and writes to undefined bits, show that they land in the copy, are ignored, or are overwritten, each as its requirement states.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic       cb;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  typedef enum logic [2:0] {
    OFF_CTL, OFF_SEC, OFF_MIN, OFF_HR, OFF_DAY, OFF_DATE, OFF_MON, OFF_YR
  } reg_off_e;

  localparam rtc_time_t TIME_RST = '{cb: 1'b0, yr: 8'h00, mon: 5'h01, date: 6'h01,
                                     dow: 3'd1, hr: 6'h00, min: 7'h00, sec: 7'h00};

  // Two-digit BCD increment; caller handles the wrap value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year is a multiple of four, evaluated on BCD digits.
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      stop,
  input  logic      ceb,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  rtc_time_t nxt;

  always_comb begin
    nxt = now;
    nxt.sec = 7'(bcd_inc({1'b0, now.sec}));
    if (now.sec >= 7'h59) begin
      nxt.sec = '0;
      nxt.min = 7'(bcd_inc({1'b0, now.min}));
      if (now.min >= 7'h59) begin
        nxt.min = '0;
        nxt.hr  = 6'(bcd_inc({2'b0, now.hr}));
        if (now.hr >= 6'h23) begin
          nxt.hr   = '0;
          nxt.dow  = (now.dow >= 3'd7) ? 3'd1 : now.dow + 3'd1;
          nxt.date = 6'(bcd_inc({2'b0, now.date}));
          if (now.date >= month_last(now.mon, now.yr)) begin
            nxt.date = 6'h01;
            nxt.mon  = 5'(bcd_inc({3'b0, now.mon}));
            if (now.mon >= 5'h12) begin
              nxt.mon = 5'h01;
              nxt.yr  = bcd_inc(now.yr);
              if (now.yr == 8'h99) begin
                nxt.yr = 8'h00;
                if (ceb) nxt.cb = ~now.cb;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             now <= TIME_RST;
    else if (load)          now <= load_val;
    else if (tick && !stop) now <= nxt;
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] off,
  input  logic [7:0] wdata,
  input  logic       refresh_req,
  input  rtc_time_t  now,
  output rtc_time_t  sh,
  output logic [7:0] rmux,
  output logic       halt,
  output logic       stop,
  output logic       ceb,
  output logic       commit
);
  logic ctl_w, ctl_r;

  assign halt   = ctl_w | ctl_r;
  assign commit = wr && (reg_off_e'(off) == OFF_CTL) && ctl_w && !wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_w <= 1'b0;
      ctl_r <= 1'b0;
      stop  <= 1'b1;
      ceb   <= 1'b0;
      sh    <= TIME_RST;
    end else begin
      if (refresh_req && !halt) sh <= now;
      if (wr) begin
        case (reg_off_e'(off))
          OFF_CTL:  begin ctl_w <= wdata[7]; ctl_r <= wdata[6]; end
          OFF_SEC:  begin sh.sec <= wdata[6:0]; stop <= wdata[7]; end
          OFF_MIN:  sh.min  <= wdata[6:0];
          OFF_HR:   sh.hr   <= wdata[5:0];
          OFF_DAY:  begin
            sh.dow <= wdata[2:0];
            ceb    <= wdata[5];
            if (ctl_w) sh.cb <= wdata[4];
          end
          OFF_DATE: sh.date <= wdata[5:0];
          OFF_MON:  sh.mon  <= wdata[4:0];
          OFF_YR:   sh.yr   <= wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_off_e'(off))
      OFF_CTL:  rmux = {ctl_w, ctl_r, 6'b0};
      OFF_SEC:  rmux = {stop, sh.sec};
      OFF_MIN:  rmux = {1'b0, sh.min};
      OFF_HR:   rmux = {2'b0, sh.hr};
      OFF_DAY:  rmux = {2'b0, ceb, sh.cb, 1'b0, sh.dow};
      OFF_DATE: rmux = {2'b0, sh.date};
      OFF_MON:  rmux = {3'b0, sh.mon};
      default:  rmux = sh.yr;
    endcase
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              rd_valid
);
  localparam int OFF_W = 3;

  logic       hit, wr_hit, upd_q, stop_q, ceb_q, commit, halt;
  logic [7:0] rmux;
  rtc_time_t  now_t, sh_t;

  assign hit    = &addr[ADDR_W-1:OFF_W];
  assign wr_hit = wr_en && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q    <= 1'b0;
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      upd_q    <= sec_tick;
      rd_valid <= rd_en && hit;
      if (rd_en && hit) rdata <= rmux;
    end
  end

  rtc_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .stop(stop_q), .ceb(ceb_q),
    .load(commit), .load_val(sh_t), .now(now_t)
  );

  rtc_shadow u_shd (
    .clk(clk), .rst_n(rst_n), .wr(wr_hit), .off(addr[OFF_W-1:0]), .wdata(wdata),
    .refresh_req(upd_q), .now(now_t), .sh(sh_t), .rmux(rmux), .halt(halt),
    .stop(stop_q), .ceb(ceb_q), .commit(commit)
  );
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       hit,
  input logic       rd_valid,
  input logic [2:0] off,
  input logic [7:0] rdata,
  input logic       stop,
  input logic       ceb,
  input logic       load,
  input rtc_time_t  load_val,
  input rtc_time_t  now,
  input logic       halt,
  input logic       wr_hit,
  input logic       upd_q,
  input rtc_time_t  shadow
);
  // R1
  rd_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> !rd_valid);
  // R1
  rd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit) |=> rd_valid);
  // R10
  ctl_mbz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit && off == 3'd0) |=> (rdata[5:0] == 6'd0));
  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> $stable(now));
  // R5
  cb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceb && !load) |=> $stable(now.cb));
  // R7
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (now == $past(load_val)));
  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_hit) |=> $stable(shadow));
  // R12
  refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !halt && !wr_hit) |=> (shadow == $past(now)));
endmodule

bind rtc_regfile rtc_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .hit(hit), .rd_valid(rd_valid),
  .off(addr[2:0]), .rdata(rdata), .stop(stop_q), .ceb(ceb_q), .load(commit),
  .load_val(sh_t), .now(now_t), .halt(halt), .wr_hit(wr_hit), .upd_q(upd_q),
  .shadow(sh_t)
);

// File: tb/rtc_regfile_tb.sv
module rtc_regfile_tb_top;
  localparam int ADDR_W = 15;
  localparam logic [ADDR_W-1:0] BASE = 15'h7FF8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sec_tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wdata = '0;
  logic              rd_en = 1'b0;
  logic [7:0]        rdata;
  logic              rd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  rtc_regfile #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid)
  );

  // Monitor: pops one expected byte per read result.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rd_valid) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R1: unexpected rd_valid, rdata=%02h expected no data", rdata);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rdata !== e.v) begin
            fails++;
            $display("FAIL %s: rdata=%02h expected %02h", e.tag, rdata, e.v);
          end
        end
      end
    end
  end

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    addr = BASE + ADDR_W'(off); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] off, input logic [7:0] e, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    @(negedge clk);
    addr = BASE + ADDR_W'(off); rd_en = 1'b1;
    sb.push_back(x);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_outside(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rd_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rd_valid=%0b for address %04h expected 0", rd_valid, a);
    end
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Load a time one second before a boundary through the load bit.
  task automatic load_edge(input logic [7:0] day, input logic [7:0] date,
                           input logic [7:0] mon, input logic [7:0] yr);
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h59); wr(3'd2, 8'h59); wr(3'd3, 8'h23);
    wr(3'd4, day); wr(3'd5, date); wr(3'd6, mon); wr(3'd7, yr);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 reset state
    rd(3'd0, 8'h00, "R2"); rd(3'd1, 8'h80, "R2"); rd(3'd2, 8'h00, "R2");
    rd(3'd3, 8'h00, "R2"); rd(3'd4, 8'h01, "R2"); rd(3'd5, 8'h01, "R2");
    rd(3'd6, 8'h01, "R2"); rd(3'd7, 8'h00, "R2");
    // R1 window decode
    rd_outside(15'h0123);
    rd_outside(15'h7FF7);
    // R8 stopped after reset
    tick();
    rd(3'd1, 8'h80, "R8");

    // R7 load, R3 carries, R4 non-leap February, R9 century flag with load bit
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h58); wr(3'd2, 8'h59); wr(3'd3, 8'h23); wr(3'd4, 8'h37);
    wr(3'd5, 8'h28); wr(3'd6, 8'h02); wr(3'd7, 8'h99);
    rd(3'd4, 8'h37, "R9");
    wr(3'd0, 8'h00);
    rd(3'd1, 8'h58, "R7");
    tick();
    rd(3'd1, 8'h59, "R7");
    tick();
    rd(3'd1, 8'h00, "R3"); rd(3'd2, 8'h00, "R3"); rd(3'd3, 8'h00, "R3");
    rd(3'd4, 8'h31, "R3"); rd(3'd5, 8'h01, "R4"); rd(3'd6, 8'h03, "R4");
    rd(3'd7, 8'h99, "R4");

    // R5 year wrap with century enable
    load_edge(8'h37, 8'h31, 8'h12, 8'h99);
    tick();
    rd(3'd7, 8'h00, "R5"); rd(3'd6, 8'h01, "R5"); rd(3'd5, 8'h01, "R5");
    rd(3'd4, 8'h21, "R5");
    // R5 year wrap without century enable
    load_edge(8'h07, 8'h31, 8'h12, 8'h99);
    tick();
    rd(3'd7, 8'h00, "R5"); rd(3'd4, 8'h01, "R5");

    // R9 century flag ignored without load bit, enable writable
    wr(3'd4, 8'h17);
    rd(3'd4, 8'h07, "R9");
    wr(3'd4, 8'h27);
    rd(3'd4, 8'h27, "R9");
    // R11 direct writes overwritten by refresh
    tick();
    rd(3'd4, 8'h21, "R11"); rd(3'd1, 8'h01, "R11");
    wr(3'd2, 8'h45);
    rd(3'd2, 8'h45, "R11");
    tick();
    rd(3'd2, 8'h00, "R11"); rd(3'd1, 8'h02, "R11");

    // R10 undefined bits
    wr(3'd0, 8'h3F);
    rd(3'd0, 8'h00, "R10");
    wr(3'd3, 8'hD2);
    rd(3'd3, 8'h12, "R10");

    // R4 leap February (year 12), then into March, then 30-day month
    load_edge(8'h03, 8'h28, 8'h02, 8'h12);
    tick();
    rd(3'd5, 8'h29, "R4"); rd(3'd6, 8'h02, "R4"); rd(3'd4, 8'h04, "R3");
    load_edge(8'h04, 8'h29, 8'h02, 8'h12);
    tick();
    rd(3'd5, 8'h01, "R4"); rd(3'd6, 8'h03, "R4");
    load_edge(8'h04, 8'h30, 8'h04, 8'h12);
    tick();
    rd(3'd5, 8'h01, "R4"); rd(3'd6, 8'h05, "R4");

    // R6 freeze
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h30); wr(3'd2, 8'h20); wr(3'd3, 8'h10);
    wr(3'd0, 8'h00);
    rd(3'd1, 8'h30, "R6");
    wr(3'd0, 8'h40);
    rd(3'd0, 8'h40, "R6");
    tick();
    rd(3'd1, 8'h30, "R6"); rd(3'd2, 8'h20, "R6");
    wr(3'd0, 8'h00);
    rd(3'd1, 8'h30, "R6");
    tick();
    rd(3'd1, 8'h32, "R6"); rd(3'd2, 8'h20, "R12"); rd(3'd3, 8'h10, "R12");

    // R8 stop while running
    wr(3'd1, 8'hB2);
    rd(3'd1, 8'hB2, "R8");
    tick(); tick();
    rd(3'd1, 8'hB2, "R8");
    wr(3'd1, 8'h32);
    tick();
    rd(3'd1, 8'h33, "R8");

    // R7 load bit holds the copy; commit restores the loaded value
    wr(3'd0, 8'h80);
    tick();
    rd(3'd1, 8'h33, "R7");
    wr(3'd0, 8'h00);
    rd(3'd1, 8'h33, "R7");
    tick();
    rd(3'd1, 8'h34, "R7");

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d reads without result, expected 0", sb.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule